// File: doc/BRIEF.md
# Reaction Time Measurement Unit

This block measures how long a person takes to respond once a ready lamp turns on. A start trigger, produced elsewhere after a random wait, lights the lamp and starts a decimal millisecond counter. The first rising edge of the stop pushbutton while the lamp is lit turns the lamp off and holds the count, so that display logic can show it as four BCD digits. A synchronous clear returns the block to its idle state for the next attempt.

The millisecond tick comes from a prescaler that divides the system clock by `TICK_DIV`. The default of 50,000 gives 1 ms at 50 MHz. The prescaler stays at zero while the lamp is off, so the first tick comes exactly one millisecond after the lamp turns on. The count saturates at 9999, which is 9.999 s.

Top module: `rxn_timer`

## Requirements
- R1: After `rst_ni` is asserted, `lamp_o` is 0 and `digits_o` is 0x0000.
- R2: In the idle state, `trig_i` high at a clock edge with `clear_i` low moves the block to the running state at that edge: `lamp_o` is 1 from that edge on, and `digits_o` is still 0x0000.
- R3: While running, the count goes up by exactly one each `TICK_DIV` clock cycles. The first increment comes `TICK_DIV` edges after the edge at which the lamp turned on. At no other time does the count change, except on clear.
- R4: `digits_o` is four BCD digits, with the least significant in bits [3:0]. A digit that advances past 9 returns to 0 and carries one into the next digit (0009→0010, 0099→0100, 0999→1000).
- R5: A rising edge on `stop_i` while running passes through a two-flop synchroniser. The block is frozen at the third clock edge after `stop_i` rises: `lamp_o` goes to 0 and `digits_o` is held from then on.
- R6: A `stop_i` press while idle or frozen has no effect on `lamp_o` or `digits_o`.
- R7: `trig_i` is ignored while running or frozen, and only `clear_i` leaves the frozen state.
- R8: `clear_i` high at a clock edge forces the idle state, turns the lamp off and sets the count to 0x0000. It takes priority over `trig_i`.
- R9: At 9999 the count stays at 9999 instead of wrapping, and the lamp stays on until stop or clear.
- R10: Each digit of `digits_o` always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous clear; restarts the cycle |
| trig_i | input | 1 | Start trigger; lights the lamp while idle |
| stop_i | input | 1 | Stop pushbutton, asynchronous, active high |
| lamp_o | output | 1 | Ready lamp, high while running |
| digits_o | output | 16 | Elapsed milliseconds as four BCD digits |

## Verification
Every cycle, the assertions check these properties:
- the state moves for start, freeze and clear;
- the frozen state holds;
- the prescaler stays at zero outside the running state;
- ticks are never back to back;
- the digits stay legal;
- the count holds when there is no tick;
- the count holds at saturation.

Only the bench's scenarios can show the following:
- the exact millisecond value at each tick boundary;
- the three-edge latency from a stop press to the freeze;
- the carry points at 10, 100 and 1000;
- that stop and trigger presses at the wrong time leave the outputs alone.

The bench's reference model counts ticks in integers and converts them to BCD on its own. It is compared with the outputs on every clock.

// File: rtl/rxn_pkg.sv
package rxn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FROZEN = 2'd2
  } rxn_state_e;

  localparam int unsigned BCD_W = 4;
endpackage

// File: rtl/rxn_tick_gen.sv
module rxn_tick_gen #(
  parameter int unsigned TICK_DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the divider stays at zero outside the running state
  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

  generate
    if (TICK_DIV > 1) begin : g_gap
      a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rxn_bcd_chain.sv
module rxn_bcd_chain #(
  parameter int unsigned N_DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*N_DIGITS-1:0] digits_o
);
  import rxn_pkg::*;

  localparam int unsigned DW = BCD_W * N_DIGITS;
  localparam logic [DW-1:0] ALL_NINES = {N_DIGITS{4'h9}};

  logic [N_DIGITS:0] carry;
  logic              sat;

  assign sat      = (digits_o == ALL_NINES);
  assign carry[0] = inc_i && !sat;

  generate
    for (genvar i = 0; i < N_DIGITS; i++) begin : g_dig
      logic [BCD_W-1:0] d_q;

      assign carry[i+1]            = carry[i] && (d_q == 4'd9);
      assign digits_o[i*BCD_W +: BCD_W] = d_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          d_q <= '0;
        end else if (clr_i) begin
          d_q <= '0;
        end else if (carry[i]) begin
          d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
        end
      end

      a_r10_digit_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        d_q <= 4'd9);
    end
  endgenerate

  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat && !clr_i |=> (digits_o == ALL_NINES));

  a_r3_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !clr_i |=> $stable(digits_o));

  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (digits_o == '0));
endmodule

// File: rtl/rxn_ctrl.sv
module rxn_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic trig_i,
  input  logic stop_i,
  output logic run_o
);
  import rxn_pkg::*;

  rxn_state_e             state_q, state_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   stop_prev_q;
  logic                   stop_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q      <= '0;
      stop_prev_q <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], stop_i};
      stop_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign stop_rise = sync_q[SYNC_STAGES-1] && !stop_prev_q;

  always_comb begin
    state_d = state_q;
    if (clear_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (trig_i)    state_d = ST_RUN;
        ST_RUN:    if (stop_rise) state_d = ST_FROZEN;
        ST_FROZEN: state_d = ST_FROZEN;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign run_o = (state_q == ST_RUN);

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && trig_i && !clear_i |=> (state_q == ST_RUN));

  a_r6_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && !trig_i && !clear_i |=> (state_q == ST_IDLE));

  a_r5_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) && stop_rise && !clear_i |=> (state_q == ST_FROZEN));

  a_r7_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FROZEN) && !clear_i |=> (state_q == ST_FROZEN));

  a_r8_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/rxn_timer.sv
module rxn_timer #(
  parameter int unsigned TICK_DIV    = 50000,
  parameter int unsigned N_DIGITS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  trig_i,
  input  logic                  stop_i,
  output logic                  lamp_o,
  output logic [4*N_DIGITS-1:0] digits_o
);
  logic run;
  logic tick;

  rxn_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .trig_i  (trig_i),
    .stop_i  (stop_i),
    .run_o   (run)
  );

  rxn_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  rxn_bcd_chain #(.N_DIGITS(N_DIGITS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clear_i),
    .inc_i    (tick),
    .digits_o (digits_o)
  );

  assign lamp_o = run;

  a_r5_lamp_off_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lamp_o && !clear_i |=> $stable(digits_o));
endmodule

// File: tb/sim_rxn_timer.sv
module sim_rxn_timer;
  localparam int DIV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        trig = 1'b0;
  logic        stop = 1'b0;
  logic        lamp;
  logic [15:0] digits;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rxn_timer #(.TICK_DIV(DIV), .N_DIGITS(4), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .trig_i(trig),
    .stop_i(stop), .lamp_o(lamp), .digits_o(digits)
  );

  // behavioural reference: 0 idle, 1 running, 2 frozen
  int m_state, m_pre, m_ms;
  bit sd0, sd1, sd2;

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int x = v;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_pre = 0; m_ms = 0; sd0 = 0; sd1 = 0; sd2 = 0;
    end else begin
      bit rise, tk;
      rise = sd1 && !sd2;
      tk   = (m_state == 1) && (m_pre == DIV - 1);
      if (clear) begin
        m_state = 0; m_pre = 0; m_ms = 0;
      end else begin
        if (tk && m_ms < 9999) m_ms++;
        m_pre = (m_state == 1 && !tk) ? m_pre + 1 : 0;
        if (m_state == 0 && trig) m_state = 1;
        else if (m_state == 1 && rise) m_state = 2;
      end
      sd2 = sd1; sd1 = sd0; sd0 = stop;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison: R2/R3 lamp and count, R4 BCD form
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model lamp", {31'd0, lamp}, {31'd0, m_state == 1});
      chk("R3 R4 model count", {16'd0, digits}, {16'd0, to_bcd(m_ms)});
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R1 reset lamp", {31'd0, lamp}, 32'd0);
    chk("R1 reset digits", {16'd0, digits}, 32'h0);
    rst_n = 1'b1;
    wait_n(2);

    // R6: stop while idle
    stop = 1'b1; wait_n(5); stop = 1'b0; wait_n(5);
    chk("R6 idle stop lamp", {31'd0, lamp}, 32'd0);
    chk("R6 idle stop digits", {16'd0, digits}, 32'h0);

    // R2: trigger
    trig = 1'b1; wait_n(1); trig = 1'b0;
    chk("R2 lamp on", {31'd0, lamp}, 32'd1);
    chk("R2 count zero", {16'd0, digits}, 32'h0);
    wait_n(DIV - 1);
    chk("R3 before first tick", {16'd0, digits}, 32'h0);
    wait_n(1);
    chk("R3 first tick", {16'd0, digits}, 32'h1);
    wait_n(DIV * 11);
    chk("R4 carry to 0012", {16'd0, digits}, 32'h0012);

    // R7: trigger while running ignored
    trig = 1'b1; wait_n(1); trig = 1'b0;
    chk("R7 trig in run lamp", {31'd0, lamp}, 32'd1);

    // R5: stop press, frozen at third edge
    stop = 1'b1;
    wait_n(2);
    chk("R5 lamp still on", {31'd0, lamp}, 32'd1);
    wait_n(1);
    chk("R5 lamp off", {31'd0, lamp}, 32'd0);
    chk("R5 frozen value", {16'd0, digits}, 32'h0012);
    wait_n(50);
    chk("R5 held", {16'd0, digits}, 32'h0012);
    stop = 1'b0; wait_n(4);

    // R6/R7: stop and trigger while frozen
    stop = 1'b1; wait_n(5); stop = 1'b0;
    trig = 1'b1; wait_n(1); trig = 1'b0; wait_n(30);
    chk("R6 frozen stop digits", {16'd0, digits}, 32'h0012);
    chk("R7 frozen trig lamp", {31'd0, lamp}, 32'd0);

    // R8: clear wins over trigger
    clear = 1'b1; trig = 1'b1; wait_n(1); clear = 1'b0; trig = 1'b0;
    chk("R8 clear lamp", {31'd0, lamp}, 32'd0);
    chk("R8 clear digits", {16'd0, digits}, 32'h0);
    wait_n(DIV * 2);
    chk("R8 stays idle", {31'd0, lamp}, 32'd0);

    // R4/R9: long run to saturation
    trig = 1'b1; wait_n(1); trig = 1'b0;
    wait_n(DIV * 999);
    chk("R4 at 0999", {16'd0, digits}, 32'h0999);
    wait_n(DIV);
    chk("R4 carry 1000", {16'd0, digits}, 32'h1000);
    wait_n(DIV * 8999);
    chk("R9 reach 9999", {16'd0, digits}, 32'h9999);
    wait_n(DIV * 30);
    chk("R9 saturated", {16'd0, digits}, 32'h9999);
    chk("R9 lamp on", {31'd0, lamp}, 32'd1);
    stop = 1'b1; wait_n(3); stop = 1'b0;
    chk("R5 stop after sat", {31'd0, lamp}, 32'd0);
    wait_n(5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule